// File: doc/BRIEF.md
# I/O Bus Cycle Wait-State Sequencer

This block is the host side of a PC/104-style I/O channel. It runs one I/O read or one I/O write at a time. A start request carries an address, a direction and write data. The sequencer then drives an address strobe for one clock and asserts the matching active-low command. It holds that command for a base clock plus a number of wait states, and then releases it.

The number of wait states is chosen per cycle from the addressed device's reply. If the device pulls the active-low 16-bit select low while address-enable is low (no DMA ownership), the cycle is a short 16-bit one with a single wait state. Otherwise the cycle is a default 8-bit one with four wait states. Once those default waits have passed, a slow device can hold the channel-ready line low to add whole clocks to the command. A programmable limit stops the cycle with an error flag if ready stays low for too long.

For a read, the data bus is captured on the last command clock. A one-clock done pulse, together with the captured data and the error flag, follows right after the command is released.

Top module: `io_cycle_seq`

## Requirements
- R1: A start request is accepted only while `busy_o` is low. On acceptance, `bus_ale_o` is high for exactly one clock with `bus_addr_o` equal to the requested address, and the command asserts in the next clock.
- R2: A read drives `bus_rd_n_o` low and a write drives `bus_wr_n_o` low; never both at once. During a write command, `bus_data_oe_o` is 1 and `bus_data_o` carries the requested write data.
- R3: `bus_addr_o` stays unchanged from the strobe clock to the end of the command.
- R4: When `bus_sel16_n_i` is 0 and `bus_aen_i` is 0 at the sample point, the command lasts 2 clocks (1 wait state), provided ready is high.
- R5: When `bus_sel16_n_i` is 1, or `bus_aen_i` is 1, at the sample point, the command lasts 5 clocks (4 wait states), provided ready is high.
- R6: The 16-bit select is sampled once, at the clock edge that ends the strobe clock. Any later change of `bus_sel16_n_i` within the cycle does not alter the command length.
- R7: `bus_ready_i` is examined only from the last default command clock onward. Each examined clock with ready at 0 adds one command clock. A low ready during earlier command clocks has no effect.
- R8: If ready is still 0 at an examined clock after `tmo_limit_i` extra clocks have already been added, the command ends at that clock and `err_o` is 1 with the done pulse. `err_o` is never 1 without `done_o`.
- R9: On a read, `rdata_o` holds the value of `bus_data_i` from the last command clock. `done_o` is a single-clock pulse in the clock right after the command is released.
- R10: A start request that arrives while a cycle is in progress is ignored: no second strobe and no second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a cycle |
| start_write_i | input | 1 | 1 = write, 0 = read |
| start_addr_i | input | AW | Cycle address |
| start_wdata_i | input | DW | Write data |
| tmo_limit_i | input | TW | Maximum number of ready-extension clocks |
| bus_ale_o | output | 1 | Address strobe, high one clock |
| bus_addr_o | output | AW | Latched address |
| bus_rd_n_o | output | 1 | Active-low read command |
| bus_wr_n_o | output | 1 | Active-low write command |
| bus_data_o | output | DW | Write data to the bus |
| bus_data_oe_o | output | 1 | Write data drive enable |
| bus_data_i | input | DW | Read data from the bus |
| bus_sel16_n_i | input | 1 | Active-low 16-bit cycle claim |
| bus_aen_i | input | 1 | Address-enable (DMA owns bus when 1) |
| bus_ready_i | input | 1 | Channel ready, 0 = stretch |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Cycle ended on timeout (valid with done) |
| rdata_o | output | DW | Captured read data |

## Verification
The end of the default wait count and the ready check land on the same command clock, so a low ready and the end of the cycle compete there. The bench provokes this by holding ready low for exactly the default count of command clocks, which must leave the length unchanged, and then for longer. In the longer case, the length must grow by one clock for each extra low clock. The timeout and the ready extension also meet on one clock. Holding ready low so the limit is reached exactly, and exceeded by one, separates a clean finish from an error finish. Each is judged by the command length, the error flag and the captured read data, which the bench makes unique to each command clock.

// File: rtl/io_cycle_pkg.sv
package io_cycle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALE  = 2'd1,
        ST_CMD  = 2'd2,
        ST_DONE = 2'd3
    } cyc_state_e;

endpackage

// File: rtl/io_cycle_fsm.sv
module io_cycle_fsm
    import io_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wait_over_i,
    input  logic       ready_i,
    input  logic       tmo_hit_i,
    output cyc_state_e state_o,
    output logic       accept_o,
    output logic       load_o,
    output logic       finish_o,
    output logic       timeout_o,
    output logic       extend_o
);

    typedef struct packed {
        cyc_state_e state;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        accept_o  = 1'b0;
        load_o    = 1'b0;
        finish_o  = 1'b0;
        timeout_o = 1'b0;
        extend_o  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o  = 1'b1;
                    r_d.state = ST_ALE;
                end
            end
            ST_ALE: begin
                load_o    = 1'b1;
                r_d.state = ST_CMD;
            end
            ST_CMD: begin
                if (wait_over_i) begin
                    if (ready_i) begin
                        finish_o  = 1'b1;
                        r_d.state = ST_DONE;
                    end else if (tmo_hit_i) begin
                        finish_o  = 1'b1;
                        timeout_o = 1'b1;
                        r_d.state = ST_DONE;
                    end else begin
                        extend_o = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/io_wait_timer.sv
module io_wait_timer #(
    parameter int WS_WIDE   = 1,
    parameter int WS_NARROW = 4,
    parameter int TW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          wide_i,
    input  logic          in_cmd_i,
    input  logic          extend_i,
    input  logic [TW-1:0] limit_i,
    output logic          wait_over_o,
    output logic          tmo_hit_o
);

    localparam int WS_MAX = (WS_NARROW > WS_WIDE) ? WS_NARROW : WS_WIDE;
    localparam int WCW    = $clog2(WS_MAX + 1);

    typedef struct packed {
        logic [WCW-1:0] wcnt;
        logic [TW-1:0]  ext;
    } timer_regs_t;

    timer_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.wcnt = wide_i ? WCW'(WS_WIDE) : WCW'(WS_NARROW);
            r_d.ext  = '0;
        end else if (in_cmd_i && (r_q.wcnt != '0)) begin
            r_d.wcnt = r_q.wcnt - WCW'(1);
        end else if (extend_i) begin
            r_d.ext = r_q.ext + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.wcnt <= '0;
            r_q.ext  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wait_over_o = (r_q.wcnt == '0);
    assign tmo_hit_o   = (r_q.ext >= limit_i);

endmodule

// File: rtl/io_cycle_datapath.sv
module io_cycle_datapath #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          finish_i,
    input  logic          timeout_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] bus_data_i,
    output logic [AW-1:0] addr_o,
    output logic          write_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o,
    output logic          err_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          write;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          err;
    } dp_regs_t;

    dp_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (accept_i) begin
            r_d.addr  = addr_i;
            r_d.write = write_i;
            r_d.wdata = wdata_i;
            r_d.err   = 1'b0;
        end
        if (finish_i) begin
            if (!r_q.write) begin
                r_d.rdata = bus_data_i;
            end
            r_d.err = timeout_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.addr  <= '0;
            r_q.write <= 1'b0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o  = r_q.addr;
    assign write_o = r_q.write;
    assign wdata_o = r_q.wdata;
    assign rdata_o = r_q.rdata;
    assign err_o   = r_q.err;

endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
    import io_cycle_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int TW        = 8,
    parameter int WS_WIDE   = 1,
    parameter int WS_NARROW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          start_write_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [DW-1:0] start_wdata_i,
    input  logic [TW-1:0] tmo_limit_i,
    output logic          bus_ale_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_rd_n_o,
    output logic          bus_wr_n_o,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_data_oe_o,
    input  logic [DW-1:0] bus_data_i,
    input  logic          bus_sel16_n_i,
    input  logic          bus_aen_i,
    input  logic          bus_ready_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o
);

    cyc_state_e state;
    logic accept, load, finish, timeout, extend;
    logic wait_over, tmo_hit, in_cmd, wide;
    logic write_q, err_q;

    io_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .wait_over_i (wait_over),
        .ready_i     (bus_ready_i),
        .tmo_hit_i   (tmo_hit),
        .state_o     (state),
        .accept_o    (accept),
        .load_o      (load),
        .finish_o    (finish),
        .timeout_o   (timeout),
        .extend_o    (extend)
    );

    assign in_cmd = (state == ST_CMD);
    assign wide   = !bus_sel16_n_i && !bus_aen_i;

    io_wait_timer #(
        .WS_WIDE   (WS_WIDE),
        .WS_NARROW (WS_NARROW),
        .TW        (TW)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .wide_i      (wide),
        .in_cmd_i    (in_cmd),
        .extend_i    (extend),
        .limit_i     (tmo_limit_i),
        .wait_over_o (wait_over),
        .tmo_hit_o   (tmo_hit)
    );

    io_cycle_datapath #(
        .AW (AW),
        .DW (DW)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .finish_i   (finish),
        .timeout_i  (timeout),
        .write_i    (start_write_i),
        .addr_i     (start_addr_i),
        .wdata_i    (start_wdata_i),
        .bus_data_i (bus_data_i),
        .addr_o     (bus_addr_o),
        .write_o    (write_q),
        .wdata_o    (bus_data_o),
        .rdata_o    (rdata_o),
        .err_o      (err_q)
    );

    assign bus_ale_o     = (state == ST_ALE);
    assign bus_rd_n_o    = !(in_cmd && !write_q);
    assign bus_wr_n_o    = !(in_cmd && write_q);
    assign bus_data_oe_o = in_cmd && write_q;
    assign busy_o        = (state != ST_IDLE);
    assign done_o        = (state == ST_DONE);
    assign err_o         = (state == ST_DONE) && err_q;

endmodule

// File: rtl/io_cycle_seq_chk.sv
module io_cycle_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_ale_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          bus_rd_n_o,
    input logic          bus_wr_n_o,
    input logic          bus_ready_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o
);

    logic cmd_on;
    assign cmd_on = !bus_rd_n_o || !bus_wr_n_o;

    p_single_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n_o && !bus_wr_n_o));

    p_ale_one_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale_o |=> !bus_ale_o);

    p_ale_then_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale_o |=> cmd_on);

    p_ale_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale_o |-> !$past(busy_o));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on |-> $stable(bus_addr_o));

    p_done_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cmd_on && $past(cmd_on)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_ready_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(bus_ready_i));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

endmodule

bind io_cycle_seq io_cycle_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ale_o   (bus_ale_o),
    .bus_addr_o  (bus_addr_o),
    .bus_rd_n_o  (bus_rd_n_o),
    .bus_wr_n_o  (bus_wr_n_o),
    .bus_ready_i (bus_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/io_cycle_seq_test.sv
module io_cycle_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_wr = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] start_wdata = '0;
    logic [7:0]  tmo_limit = 8'd3;
    logic        ale, rd_n, wr_n, oe, busy, done, err;
    logic [15:0] addr, wdata_bus, rdata, bus_din;
    logic        sel16_n = 1'b1;
    logic        aen = 1'b0;
    logic        ready;
    int          hold_clk = 0;
    int          cmd_cnt = 0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    io_cycle_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .start_write_i (start_wr),
        .start_addr_i  (start_addr),
        .start_wdata_i (start_wdata),
        .tmo_limit_i   (tmo_limit),
        .bus_ale_o     (ale),
        .bus_addr_o    (addr),
        .bus_rd_n_o    (rd_n),
        .bus_wr_n_o    (wr_n),
        .bus_data_o    (wdata_bus),
        .bus_data_oe_o (oe),
        .bus_data_i    (bus_din),
        .bus_sel16_n_i (sel16_n),
        .bus_aen_i     (aen),
        .bus_ready_i   (ready),
        .busy_o        (busy),
        .done_o        (done),
        .err_o         (err),
        .rdata_o       (rdata)
    );

    // slave model: cmd_cnt = index of the current command clock minus one
    always @(posedge clk) begin
        if (!rd_n || !wr_n) cmd_cnt <= cmd_cnt + 1;
        else                cmd_cnt <= 0;
    end
    assign ready   = !((!rd_n || !wr_n) && (cmd_cnt < hold_clk));
    assign bus_din = addr ^ 16'(cmd_cnt);

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        int          len;
        logic        err;
        logic [15:0] rdata;
        string       tag;
    } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    int  len = 0;
    bit  dir_bad = 1'b0;
    bit  addr_bad = 1'b0;
    bit  wdat_bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                check(q.size() != 0, "R10 strobe without request", 1, 0);
                if (q.size() != 0)
                    check(addr == q[0].addr, "R1 strobe address", addr, q[0].addr);
            end
            if ((!rd_n || !wr_n) && q.size() != 0) begin
                len++;
                if (addr != q[0].addr) addr_bad = 1'b1;
                if (q[0].wr ? (wr_n || !rd_n) : (rd_n || !wr_n)) dir_bad = 1'b1;
                if (q[0].wr && (!oe || wdata_bus != q[0].wdata)) wdat_bad = 1'b1;
            end
            if (done) begin
                check(q.size() != 0, "R10 done without request", 1, 0);
                if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(len == e.len, {"length ", e.tag}, len, e.len);
                    check(err == e.err, "R8 error flag", err, e.err);
                    check(!addr_bad, "R3 address held", 1, 0);
                    check(!dir_bad, "R2 command direction", 1, 0);
                    if (e.wr) check(!wdat_bad, "R2 write data drive", 1, 0);
                    else      check(rdata == e.rdata, "R9 read capture", rdata, e.rdata);
                    check(rd_n && wr_n, "R9 done after release", {rd_n, wr_n}, 3);
                end
                len = 0; addr_bad = 0; dir_bad = 0; wdat_bad = 0;
            end
        end
    end

    task automatic run_cycle(input logic wr, input logic [15:0] a, input logic [15:0] d,
                             input logic sel_n, input logic ae, input int hold,
                             input bit flip, input bit extra, input string tag);
        exp_t e;
        int w, need, ext;
        w    = (!sel_n && !ae) ? 1 : 4;
        need = hold - w;
        if (need < 0) need = 0;
        e.err = (need > int'(tmo_limit));
        ext   = e.err ? int'(tmo_limit) : need;
        e.wr = wr; e.addr = a; e.wdata = d; e.len = 1 + w + ext;
        e.rdata = a ^ 16'(e.len - 1);
        e.tag = tag;
        q.push_back(e);
        hold_clk = hold; sel16_n = sel_n; aen = ae;
        @(negedge clk);
        start = 1'b1; start_wr = wr; start_addr = a; start_wdata = d;
        @(negedge clk);                 // strobe clock
        start = 1'b0;
        @(negedge clk);                 // first command clock
        if (flip) sel16_n = ~sel_n;
        if (extra) begin
            start = 1'b1; start_addr = a ^ 16'hFFFF; start_wr = ~wr;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        if (extra) begin
            repeat (3) @(negedge clk);
            check(!busy && !ale, "R10 no second cycle", busy, 0);
        end
        sel16_n = 1'b1; aen = 1'b0; hold_clk = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rd_n && wr_n && !ale && !done && !busy && !oe, "R1 reset state",
              {rd_n, wr_n, ale, done, busy, oe}, 6'b110000);
        rst_n = 1'b1;
        @(negedge clk);
        run_cycle(0, 16'h0300, 16'h0000, 0, 0, 0, 0, 0, "R4 read 16-bit");
        run_cycle(0, 16'h0310, 16'h0000, 1, 0, 0, 0, 0, "R5 read 8-bit");
        run_cycle(1, 16'h0220, 16'hA5C3, 0, 1, 0, 0, 0, "R5 select ignored under aen");
        run_cycle(1, 16'h0224, 16'h1234, 0, 0, 3, 0, 0, "R7 write 16-bit ready low 3");
        run_cycle(0, 16'h0330, 16'h0000, 1, 0, 4, 0, 0, "R7 ready low only in default waits");
        run_cycle(0, 16'h0334, 16'h0000, 1, 0, 6, 0, 0, "R7 ready low 6");
        run_cycle(0, 16'h0340, 16'h0000, 1, 0, 7, 0, 0, "R8 limit reached exactly");
        run_cycle(0, 16'h0344, 16'h0000, 1, 0, 12, 0, 0, "R8 timeout");
        run_cycle(0, 16'h0350, 16'h0000, 0, 0, 0, 1, 0, "R6 late select release");
        run_cycle(1, 16'h0354, 16'hBEEF, 1, 0, 0, 1, 0, "R6 late select assert");
        run_cycle(0, 16'h0360, 16'h0000, 0, 0, 0, 0, 1, "R10 start while busy");
        tmo_limit = 8'd0;
        run_cycle(0, 16'h0364, 16'h0000, 0, 0, 2, 0, 0, "R8 zero limit");
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9 all cycles completed", q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule